// File: doc/BRIEF.md
# Dual-Feed Egress Stream Selector

An egress port card is fed by two redundant processing engines. Both engines handle the same ingress traffic, and each one sends its results to the card over its own link. The card therefore receives two copies of the same packet stream. This block forwards the copy from the engine that is currently active. It accepts every beat of the other copy and throws it away, so that stream never builds up backpressure.

Control logic picks the engine through a level input and can mark either engine as down. Whenever the selected engine differs from the resolved goal, a changeover is pending. The selector moves to the other feed only when no packet is open on the current feed, so no frame ever leaves truncated. On the new feed it waits for a fresh start-of-packet and discards the tail of any frame that was already under way. Three status outputs report the changeovers:

- a counter of completed changeovers;
- a counter of tails discarded on the new feed;
- a flag that rises when a pending change waits longer than a set number of cycles.

Top module: `dual_feed_egress_sel`

## Requirements
- R1: After reset the active feed is feed A (`active_src`=0), both counters read 0, `swap_late` is 0, and `o_valid` is 0 while no input beat is offered.
- R2: A beat on the active feed is presented on the output with its data, SOP and EOP markers unchanged, provided it is the SOP of a new packet (and no change is pending) or belongs to a packet already being forwarded.
- R3: The inactive feed's ready is always 1, and its beats never appear on the output.
- R4: While an active-feed beat is presented, that feed's ready equals `o_ready`, so output backpressure holds the beat.
- R5: A pending change is completed only in a cycle where no packet is open on the active feed. A packet that has started is forwarded through its EOP first.
- R6: After a changeover, non-SOP beats on the new feed are dropped. Forwarding resumes at the next SOP.
- R7: While a change is pending and no packet is open, an SOP on the old feed is dropped rather than started.
- R8: The goal feed is `prefer_src` (0 = feed A, 1 = feed B). The exception is when `eng_down[prefer_src]` is 1 and the other bit of `eng_down` is 0: then the goal is the other feed. A changeover is pending whenever the goal differs from `active_src`. Bit 0 of `eng_down` is engine A and bit 1 is engine B.
- R9: `swap_cnt` rises by exactly one, modulo its width, at each completed changeover, and is otherwise stable.
- R10: `cut_cnt` rises by one at a changeover when the new feed still has a packet open at the end of that cycle (its tail will be discarded).
- R11: `swap_late` is 1 once a change has been pending for LATE_LIMIT clock edges without completing. It returns to 0 when the change completes or is withdrawn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prefer_src | input | 1 | Engine the control plane marks active (0 A, 1 B) |
| eng_down | input | 2 | Per-engine failure indication, bit 0 A, bit 1 B |
| a_valid | input | 1 | Feed A beat valid |
| a_ready | output | 1 | Feed A beat accepted |
| a_sop | input | 1 | Feed A start of packet |
| a_eop | input | 1 | Feed A end of packet |
| a_data | input | DATA_W | Feed A data |
| b_valid | input | 1 | Feed B beat valid |
| b_ready | output | 1 | Feed B beat accepted |
| b_sop | input | 1 | Feed B start of packet |
| b_eop | input | 1 | Feed B end of packet |
| b_data | input | DATA_W | Feed B data |
| o_valid | output | 1 | Output beat valid |
| o_ready | input | 1 | Downstream ready |
| o_sop | output | 1 | Output start of packet |
| o_eop | output | 1 | Output end of packet |
| o_data | output | DATA_W | Output data |
| active_src | output | 1 | Feed currently forwarded |
| swap_cnt | output | CNT_W | Completed changeovers |
| cut_cnt | output | CNT_W | Tails discarded at changeover |
| swap_late | output | 1 | Pending change overdue |

## Verification
The bench builds the block with DATA_W of 16, CNT_W of 8 and LATE_LIMIT of 8. The short late limit lets one test hold a packet open across the whole window and watch the overdue flag rise on the eighth pending edge, then clear at the changeover. The narrow data width keeps the per-cycle stimulus table readable. That table runs both feeds in lockstep through backpressure, a changeover that lands mid-packet on the new feed, and a request that arrives while a packet is still open.

// File: rtl/dfes_pkg.sv
package dfes_pkg;

  // Open-packet state of a stream after one cycle.
  function automatic logic open_next(input logic open_q, input logic fire,
                                     input logic sop, input logic eop);
    if (!fire) return open_q;
    if (eop)   return 1'b0;
    if (sop)   return 1'b1;
    return open_q;
  endfunction

  // Resolve which feed should be active.
  function automatic logic goal_src(input logic prefer, input logic [1:0] down);
    if (down[prefer] && !down[~prefer]) return ~prefer;
    return prefer;
  endfunction

endpackage

// File: rtl/dfes_frame_track.sv
module dfes_frame_track (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic sop,
  input  logic eop,
  output logic open_q,
  output logic open_nx
);
  import dfes_pkg::*;

  assign open_nx = open_next(open_q, fire, sop, eop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) open_q <= 1'b0;
    else        open_q <= open_nx;
  end
endmodule

// File: rtl/dfes_path_mux.sv
module dfes_path_mux #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cur,
  input  logic              pend,
  input  logic [1:0]        in_valid,
  input  logic [1:0]        in_sop,
  input  logic [1:0]        in_eop,
  input  logic [DATA_W-1:0] in_data [2],
  output logic [1:0]        in_ready,
  input  logic              o_ready,
  output logic              o_valid,
  output logic              o_sop,
  output logic              o_eop,
  output logic [DATA_W-1:0] o_data,
  output logic              pkt_open
);
  import dfes_pkg::*;

  logic sel_v, sel_sop, sel_eop, pass_ok, fwd_fire;

  assign sel_v   = in_valid[cur];
  assign sel_sop = in_sop[cur];
  assign sel_eop = in_eop[cur];
  // A beat passes if it continues a forwarded packet, or opens one with no change pending.
  assign pass_ok = pkt_open || (sel_sop && !pend);

  assign o_valid  = sel_v && pass_ok;
  assign o_sop    = sel_sop;
  assign o_eop    = sel_eop;
  assign o_data   = in_data[cur];
  assign fwd_fire = o_valid && o_ready;

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      in_ready[i] = (i == int'(cur) && pass_ok) ? o_ready : 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pkt_open <= 1'b0;
    else        pkt_open <= open_next(pkt_open, fwd_fire, sel_sop, sel_eop);
  end
endmodule

// File: rtl/dfes_switch_ctl.sv
module dfes_switch_ctl #(
  parameter int   CNT_W      = 16,
  parameter int   LATE_LIMIT = 1024,
  parameter logic RESET_SRC  = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prefer,
  input  logic [1:0]       down,
  input  logic             pkt_open,
  input  logic [1:0]       open_nx,
  output logic             cur,
  output logic             pend,
  output logic             swap_fire,
  output logic [CNT_W-1:0] swap_cnt,
  output logic [CNT_W-1:0] cut_cnt,
  output logic             late
);
  import dfes_pkg::*;

  localparam int WAIT_W = $clog2(LATE_LIMIT + 1);
  localparam logic [WAIT_W-1:0] WAIT_MAX = WAIT_W'(LATE_LIMIT);

  logic [WAIT_W-1:0] wait_q;

  assign pend      = goal_src(prefer, down) != cur;
  assign swap_fire = pend && !pkt_open;
  assign late      = (wait_q == WAIT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur      <= RESET_SRC;
      swap_cnt <= '0;
      cut_cnt  <= '0;
      wait_q   <= '0;
    end else if (swap_fire) begin
      cur      <= ~cur;
      swap_cnt <= swap_cnt + 1'b1;
      if (open_nx[~cur]) cut_cnt <= cut_cnt + 1'b1;
      wait_q   <= '0;
    end else if (pend) begin
      if (wait_q != WAIT_MAX) wait_q <= wait_q + 1'b1;
    end else begin
      wait_q <= '0;
    end
  end
endmodule

// File: rtl/dual_feed_egress_sel.sv
module dual_feed_egress_sel #(
  parameter int   DATA_W     = 32,
  parameter int   CNT_W      = 16,
  parameter int   LATE_LIMIT = 1024,
  parameter logic RESET_SRC  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prefer_src,
  input  logic [1:0]        eng_down,
  input  logic              a_valid,
  output logic              a_ready,
  input  logic              a_sop,
  input  logic              a_eop,
  input  logic [DATA_W-1:0] a_data,
  input  logic              b_valid,
  output logic              b_ready,
  input  logic              b_sop,
  input  logic              b_eop,
  input  logic [DATA_W-1:0] b_data,
  output logic              o_valid,
  input  logic              o_ready,
  output logic              o_sop,
  output logic              o_eop,
  output logic [DATA_W-1:0] o_data,
  output logic              active_src,
  output logic [CNT_W-1:0]  swap_cnt,
  output logic [CNT_W-1:0]  cut_cnt,
  output logic              swap_late
);
  logic [1:0]        in_valid, in_sop, in_eop, in_ready, open_q, open_nx;
  logic [DATA_W-1:0] in_data [2];
  logic              pend, swap_fire, pkt_open;

  assign in_valid   = {b_valid, a_valid};
  assign in_sop     = {b_sop, a_sop};
  assign in_eop     = {b_eop, a_eop};
  assign in_data[0] = a_data;
  assign in_data[1] = b_data;
  assign a_ready    = in_ready[0];
  assign b_ready    = in_ready[1];

  for (genvar g = 0; g < 2; g++) begin : g_track
    dfes_frame_track u_trk (
      .clk    (clk),
      .rst_n  (rst_n),
      .fire   (in_valid[g] && in_ready[g]),
      .sop    (in_sop[g]),
      .eop    (in_eop[g]),
      .open_q (open_q[g]),
      .open_nx(open_nx[g])
    );
  end

  dfes_switch_ctl #(
    .CNT_W(CNT_W), .LATE_LIMIT(LATE_LIMIT), .RESET_SRC(RESET_SRC)
  ) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .prefer   (prefer_src),
    .down     (eng_down),
    .pkt_open (pkt_open),
    .open_nx  (open_nx),
    .cur      (active_src),
    .pend     (pend),
    .swap_fire(swap_fire),
    .swap_cnt (swap_cnt),
    .cut_cnt  (cut_cnt),
    .late     (swap_late)
  );

  dfes_path_mux #(.DATA_W(DATA_W)) u_mux (
    .clk     (clk),
    .rst_n   (rst_n),
    .cur     (active_src),
    .pend    (pend),
    .in_valid(in_valid),
    .in_sop  (in_sop),
    .in_eop  (in_eop),
    .in_data (in_data),
    .in_ready(in_ready),
    .o_ready (o_ready),
    .o_valid (o_valid),
    .o_sop   (o_sop),
    .o_eop   (o_eop),
    .o_data  (o_data),
    .pkt_open(pkt_open)
  );

  // Open state of each feed is kept for the cut accounting; the registered copy is unused here.
  logic open_q_unused;
  assign open_q_unused = ^open_q;
endmodule

// File: rtl/dfes_checker.sv
module dfes_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             a_valid,
  input logic             a_ready,
  input logic             b_valid,
  input logic             b_ready,
  input logic             o_valid,
  input logic             o_sop,
  input logic             active_src,
  input logic [CNT_W-1:0] swap_cnt,
  input logic             swap_late,
  input logic             pkt_open,
  input logic             swap_fire
);
  // R3: the feed not selected is never held off
  assert_idle_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active_src ? a_ready : b_ready));

  // R2: an output beat always has a valid beat behind it on the active feed
  assert_out_from_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid |-> (active_src ? b_valid : a_valid));

  // R5: no change of feed while a packet is open
  assert_no_midswitch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_open |=> $stable(active_src));

  // R6: a beat that is not part of an open packet goes out only as a start
  assert_start_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !pkt_open) |-> o_sop);

  // R9: the count steps once per changeover
  assert_swap_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    swap_fire |=> (swap_cnt == $past(swap_cnt) + 1'b1));

  assert_swap_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !swap_fire |=> $stable(swap_cnt));

  // R11: the overdue flag clears once the change lands
  assert_late_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    swap_fire |=> !swap_late);
endmodule

bind dual_feed_egress_sel dfes_checker #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .a_valid   (a_valid),
  .a_ready   (a_ready),
  .b_valid   (b_valid),
  .b_ready   (b_ready),
  .o_valid   (o_valid),
  .o_sop     (o_sop),
  .active_src(active_src),
  .swap_cnt  (swap_cnt),
  .swap_late (swap_late),
  .pkt_open  (pkt_open),
  .swap_fire (swap_fire)
);

// File: tb/dual_feed_egress_sel_tb_top.sv
module dual_feed_egress_sel_tb_top;
  localparam int DATA_W = 16;
  localparam int CNT_W  = 8;
  localparam int LIMIT  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prefer_src;
  logic [1:0] eng_down;
  logic a_valid, a_sop, a_eop, b_valid, b_sop, b_eop, o_ready;
  logic [DATA_W-1:0] a_data, b_data;
  logic a_ready, b_ready, o_valid, o_sop, o_eop, active_src, swap_late;
  logic [DATA_W-1:0] o_data;
  logic [CNT_W-1:0] swap_cnt, cut_cnt;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dual_feed_egress_sel #(.DATA_W(DATA_W), .CNT_W(CNT_W), .LATE_LIMIT(LIMIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .prefer_src(prefer_src), .eng_down(eng_down),
    .a_valid(a_valid), .a_ready(a_ready), .a_sop(a_sop), .a_eop(a_eop), .a_data(a_data),
    .b_valid(b_valid), .b_ready(b_ready), .b_sop(b_sop), .b_eop(b_eop), .b_data(b_data),
    .o_valid(o_valid), .o_ready(o_ready), .o_sop(o_sop), .o_eop(o_eop), .o_data(o_data),
    .active_src(active_src), .swap_cnt(swap_cnt), .cut_cnt(cut_cnt), .swap_late(swap_late)
  );

  typedef struct packed {
    logic       pr;
    logic       av, as_, ae;
    logic [7:0] ad;
    logic       bv, bs, be;
    logic [7:0] bd;
    logic       ordy, eov;
    logic [7:0] ed;
    logic       ear, ebr;
  } vec_t;

  // Per-cycle stimulus with expected output valid/data and ready values.
  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1,1'b1,1'b0,8'd10, 1'b1,1'b1,1'b0,8'd20, 1'b1, 1'b1,8'd10, 1'b1,1'b1},
    '{1'b0, 1'b1,1'b0,1'b0,8'd11, 1'b1,1'b0,1'b0,8'd21, 1'b1, 1'b1,8'd11, 1'b1,1'b1},
    '{1'b0, 1'b1,1'b0,1'b1,8'd12, 1'b1,1'b0,1'b1,8'd22, 1'b1, 1'b1,8'd12, 1'b1,1'b1},
    '{1'b0, 1'b1,1'b1,1'b1,8'd13, 1'b1,1'b1,1'b1,8'd23, 1'b0, 1'b1,8'd13, 1'b0,1'b1},
    '{1'b0, 1'b1,1'b1,1'b1,8'd13, 1'b0,1'b0,1'b0,8'd0,  1'b1, 1'b1,8'd13, 1'b1,1'b1},
    '{1'b1, 1'b1,1'b1,1'b0,8'd30, 1'b1,1'b1,1'b0,8'd40, 1'b1, 1'b0,8'd0,  1'b1,1'b1},
    '{1'b1, 1'b1,1'b0,1'b1,8'd31, 1'b1,1'b0,1'b0,8'd41, 1'b1, 1'b0,8'd0,  1'b1,1'b1},
    '{1'b1, 1'b0,1'b0,1'b0,8'd0,  1'b1,1'b0,1'b1,8'd42, 1'b1, 1'b0,8'd0,  1'b1,1'b1},
    '{1'b1, 1'b1,1'b1,1'b0,8'd60, 1'b1,1'b1,1'b0,8'd50, 1'b1, 1'b1,8'd50, 1'b1,1'b1},
    '{1'b0, 1'b1,1'b0,1'b0,8'd61, 1'b1,1'b0,1'b0,8'd51, 1'b1, 1'b1,8'd51, 1'b1,1'b1},
    '{1'b0, 1'b1,1'b0,1'b1,8'd62, 1'b1,1'b0,1'b1,8'd52, 1'b1, 1'b1,8'd52, 1'b1,1'b1},
    '{1'b0, 1'b0,1'b0,1'b0,8'd0,  1'b1,1'b1,1'b0,8'd53, 1'b1, 1'b0,8'd0,  1'b1,1'b1},
    '{1'b0, 1'b1,1'b1,1'b1,8'd70, 1'b0,1'b0,1'b0,8'd0,  1'b1, 1'b1,8'd70, 1'b1,1'b1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    a_valid = 0; a_sop = 0; a_eop = 0; a_data = '0;
    b_valid = 0; b_sop = 0; b_eop = 0; b_data = '0;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    string tag;
    prefer_src = 0; eng_down = 2'b00; o_ready = 1; idle_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk(active_src == 1'b0, "R1 active", active_src, 0);
    chk(swap_cnt == 0 && cut_cnt == 0, "R1 counters", swap_cnt + cut_cnt, 0);
    chk(swap_late == 1'b0, "R1 late", swap_late, 0);
    chk(o_valid == 1'b0, "R1 o_valid", o_valid, 0);

    // Vector table walk: R2 R3 R4 R6 R7
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      prefer_src = VEC[i].pr;
      a_valid = VEC[i].av; a_sop = VEC[i].as_; a_eop = VEC[i].ae; a_data = DATA_W'(VEC[i].ad);
      b_valid = VEC[i].bv; b_sop = VEC[i].bs;  b_eop = VEC[i].be; b_data = DATA_W'(VEC[i].bd);
      o_ready = VEC[i].ordy;
      #2;
      tag = (i == 3) ? "R4 backpressure" : (i >= 5 && i <= 7) ? "R6 R7 drop" : "R2 forward";
      chk(o_valid == VEC[i].eov, tag, o_valid, VEC[i].eov);
      if (VEC[i].eov)
        chk(o_data == DATA_W'(VEC[i].ed), tag, o_data, VEC[i].ed);
      chk(a_ready == VEC[i].ear && b_ready == VEC[i].ebr, "R3 R4 ready",
          {a_ready, b_ready}, {VEC[i].ear, VEC[i].ebr});
    end
    @(negedge clk);
    idle_inputs(); o_ready = 1;
    #1;
    chk(swap_cnt == 2, "R9 swap count", swap_cnt, 2);
    chk(cut_cnt == 1, "R10 cut count", cut_cnt, 1);
    chk(active_src == 1'b0, "R5 back on A", active_src, 0);

    // Overdue changeover: packet held open on A across the window (R11, R5, R10)
    a_valid = 1; a_sop = 1; a_eop = 0; a_data = 16'd80;
    #1;
    chk(o_valid && o_data == 16'd80, "R2 open packet", o_data, 80);
    @(negedge clk);
    idle_inputs(); prefer_src = 1;
    repeat (7) @(negedge clk);
    #1;
    chk(swap_late == 1'b0, "R11 not yet late", swap_late, 0);
    @(negedge clk);
    #1;
    chk(swap_late == 1'b1, "R11 late", swap_late, 1);
    chk(active_src == 1'b0, "R5 held", active_src, 0);
    a_valid = 1; a_sop = 0; a_eop = 1; a_data = 16'd81;
    #1;
    chk(o_valid && o_data == 16'd81, "R5 tail forwarded", o_data, 81);
    @(negedge clk);
    idle_inputs();
    #1;
    chk(active_src == 1'b0, "R5 waits for edge", active_src, 0);
    @(negedge clk);
    #1;
    chk(active_src == 1'b1, "R5 switched", active_src, 1);
    chk(swap_late == 1'b0, "R11 cleared", swap_late, 0);
    chk(swap_cnt == 3, "R9 swap count", swap_cnt, 3);
    chk(cut_cnt == 2, "R10 open tail on B", cut_cnt, 2);

    // Engine failure overrides preference (R8)
    eng_down = 2'b10;
    @(negedge clk);
    #1;
    chk(active_src == 1'b0, "R8 failover", active_src, 0);
    chk(swap_cnt == 4, "R9 swap count", swap_cnt, 4);
    prefer_src = 0; eng_down = 2'b11;
    repeat (2) @(negedge clk);
    #1;
    chk(active_src == 1'b0 && swap_cnt == 4, "R8 both down keeps preference", swap_cnt, 4);
    eng_down = 2'b00;

    // Inactive feed ignored (R3)
    b_valid = 1; b_sop = 1; b_eop = 0; b_data = 16'd90;
    #1;
    chk(!o_valid && b_ready, "R3 idle feed start", o_valid, 0);
    @(negedge clk);
    b_sop = 0; b_eop = 1; b_data = 16'd91;
    #1;
    chk(!o_valid && b_ready, "R3 idle feed end", o_valid, 0);
    @(negedge clk);
    idle_inputs();
    @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule